// File: doc/BRIEF.md
# Pull Resistor Configuration Sequencer

This block holds the pull-resistor setting of every pin of a 54-pin port and drives one pull-up enable and one pull-down enable per pin toward the pads. Software never writes a pin's pull setting directly. It first places a 2-bit mode in a global mode register. It then raises the pin's bit in one of two per-bank strobe registers. The low-to-high change of a strobe bit copies the mode into that pin alone. All other pins keep what they hold. The per-pin settings are not readable over the bus. Only the mode and strobe registers read back.

Software is expected to let the pads settle for about 150 cycles between the steps: mode write, strobe set, strobe clear. To support this, a settle flag in a status register reads busy for a fixed number of cycles after each write to the mode or strobe registers. The block does not enforce the wait. It only reports it. Register access goes over a simple 32-bit write/read bus with a combinational read path.

Top module: `pullseq_top`

## Requirements
- R1: After reset every pull-up and pull-down enable is 0, and the mode register, both strobe registers and the status register read 0.
- R2: The mode register at offset 0x94 stores bits [1:0] of a write and reads them back; bits [31:2] read 0.
- R3: The strobe register at 0x98 maps pins 0..31 to bits 0..31. The strobe register at 0x9C maps pins 32..53 to bits 0..21. Each reads back its last written bits, and bits 22..31 at 0x9C read 0.
- R4: A write that takes a pin's strobe bit from 0 to 1 loads that pin's setting from the mode register value held before that write. The pin's enables show the new value from the clock edge of that write onward.
- R5: Mode 1 asserts only the pin's pull-down enable. Mode 2 asserts only its pull-up enable. Modes 0 and 3 assert neither.
- R6: A pin whose strobe bit stays 0, stays 1 or falls keeps its setting. A write to the mode register alone changes no enable output.
- R7: Bit 0 of the status register at 0xA0 reads 1 for exactly 150 cycles after the edge of any write to 0x94, 0x98 or 0x9C, and a further such write restarts the count. Writes elsewhere do not start it.
- R8: Writes to any other offset, including 0xA0, change no register and no output. Reads of unmapped offsets return 0.
- R9: No pin ever has its pull-up and pull-down enables asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pull_up_en | output | 54 | Per-pin pull-up enable |
| pull_dn_en | output | 54 | Per-pin pull-down enable |

## Verification
Enable outputs and register read-back both change at the clock edge that accepts a write. The bench drives each write at a falling edge and waits for the rising edge. It updates its own model there and compares at the next falling edge. Reads are combinational, so the bench sets the address at a falling edge and samples a moment later. The settle flag is checked first at the falling edge right after the write. It is checked again 149 falling edges later, where it must still read busy, and once more one edge after that, where it must read idle. The same check is repeated after a restarting write.

// File: rtl/pullseq_pkg.sv
package pullseq_pkg;

  localparam logic [1:0] MODE_NONE = 2'd0;
  localparam logic [1:0] MODE_DOWN = 2'd1;
  localparam logic [1:0] MODE_UP   = 2'd2;

  // Reserved encoding 3 collapses to no pull.
  function automatic logic [1:0] mode_clean(input logic [1:0] m);
    return (m == 2'd3) ? MODE_NONE : m;
  endfunction

  function automatic int strobe_addr(input int base, input int bank);
    return base + bank * 4;
  endfunction

  function automatic int bank_of(input int pin, input int width);
    return pin / width;
  endfunction

  function automatic int bit_of(input int pin, input int width);
    return pin % width;
  endfunction

endpackage

// File: rtl/pullseq_settle.sv
module pullseq_settle #(
  parameter int SETTLE_CYC = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= CNT_W'(SETTLE_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  p_busy_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= SETTLE_CYC);
  p_idle_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

endmodule

// File: rtl/pullseq_regs.sv
module pullseq_regs
  import pullseq_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 'h94,
  parameter int CLK_BASE  = 'h98,
  parameter int STAT_ADDR = 'hA0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                busy,
  output logic [DATA_W-1:0]   rdata,
  output logic [1:0]          mode_val,
  output logic [NUM_PINS-1:0] pin_rise,
  output logic                cfg_write
);
  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;

  logic [1:0]          ctrl_q;
  logic [NUM_PINS-1:0] strobe_q;
  logic [NUM_PINS-1:0] strobe_d;
  logic                ctrl_hit;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [DATA_W-1:0]   bank_word [NUM_BANKS];

  assign ctrl_hit = wr_en && (int'(addr) == CTRL_ADDR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = wr_en && (int'(addr) == strobe_addr(CLK_BASE, b));
    for (genvar j = 0; j < DATA_W; j++) begin : g_word
      if (b * DATA_W + j < NUM_PINS) begin : g_live
        assign bank_word[b][j] = strobe_q[b * DATA_W + j];
      end else begin : g_pad
        assign bank_word[b][j] = 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int BK = bank_of(i, DATA_W);
    localparam int BT = bit_of(i, DATA_W);
    assign strobe_d[i] = bank_hit[BK] ? wdata[BT] : strobe_q[i];
    assign pin_rise[i] = bank_hit[BK] && wdata[BT] && !strobe_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= MODE_NONE;
      strobe_q <= '0;
    end else begin
      if (ctrl_hit) ctrl_q <= wdata[1:0];
      strobe_q <= strobe_d;
    end
  end

  assign mode_val  = ctrl_q;
  assign cfg_write = ctrl_hit || (|bank_hit);

  always_comb begin
    rdata = '0;
    if (int'(addr) == CTRL_ADDR) rdata[1:0] = ctrl_q;
    if (int'(addr) == STAT_ADDR) rdata[0]   = busy;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(addr) == strobe_addr(CLK_BASE, b)) rdata = bank_word[b];
    end
  end

  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> ctrl_q == $past(wdata[1:0]));
  p_ctrl_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_hit |=> $stable(ctrl_q));
  p_strobe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|bank_hit) |=> $stable(strobe_q));

endmodule

// File: rtl/pullseq_pin_cell.sv
module pullseq_pin_cell
  import pullseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] mode_in,
  output logic       up_en,
  output logic       dn_en
);
  logic [1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= MODE_NONE;
    else if (load) state_q <= mode_clean(mode_in);
  end

  assign up_en = (state_q == MODE_UP);
  assign dn_en = (state_q == MODE_DOWN);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(state_q));
  p_no_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state_q != 2'd3);

endmodule

// File: rtl/pullseq_top.sv
module pullseq_top #(
  parameter int NUM_PINS   = 54,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int SETTLE_CYC = 150,
  parameter int CTRL_ADDR  = 'h94,
  parameter int CLK_BASE   = 'h98,
  parameter int STAT_ADDR  = 'hA0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] pull_up_en,
  output logic [NUM_PINS-1:0] pull_dn_en
);
  logic [1:0]          mode_val;
  logic [NUM_PINS-1:0] pin_rise;
  logic                cfg_write;
  logic                settle_busy;

  pullseq_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .CLK_BASE (CLK_BASE),
    .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .busy     (settle_busy),
    .rdata    (bus_rdata),
    .mode_val (mode_val),
    .pin_rise (pin_rise),
    .cfg_write(cfg_write)
  );

  pullseq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .start(cfg_write),
    .busy (settle_busy)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
    pullseq_pin_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (pin_rise[i]),
      .mode_in(mode_val),
      .up_en  (pull_up_en[i]),
      .dn_en  (pull_dn_en[i])
    );
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pull_up_en & pull_dn_en)));
  p_mode_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pin_rise) |=> ($stable(pull_up_en) && $stable(pull_dn_en)));

endmodule

// File: tb/sim_pullseq_top.sv
module sim_pullseq_top;
  localparam int NP = 54;
  localparam int SETTLE = 150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pull_up_en, pull_dn_en;

  int n_chk = 0;
  int n_fail = 0;

  logic [1:0]    m_ctrl;
  logic [NP-1:0] m_strobe;
  logic [1:0]    m_state [NP];

  always #10 clk = ~clk;

  pullseq_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
  );

  function automatic logic [NP-1:0] exp_vec(input logic [1:0] code);
    logic [NP-1:0] v;
    for (int i = 0; i < NP; i++) v[i] = (m_state[i] == code);
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = 32'h0;
    if (a == 8'h94) r[1:0] = m_ctrl;
    if (a == 8'h98) r = m_strobe[31:0];
    if (a == 8'h9C) r[21:0] = m_strobe[53:32];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    logic [1:0] old_ctrl;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    old_ctrl = m_ctrl;
    if (a == 8'h94) m_ctrl = d[1:0];
    for (int i = 0; i < NP; i++) begin
      if ((i < 32 && a == 8'h98) || (i >= 32 && a == 8'h9C)) begin
        if (d[i % 32] && !m_strobe[i])
          m_state[i] = (old_ctrl == 2'd3) ? 2'd0 : old_ctrl;
        m_strobe[i] = d[i % 32];
      end
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a);
    bus_addr = a;
    #1;
    chk(tag, {32'h0, bus_rdata}, {32'h0, exp_read(a)});
  endtask

  task automatic out_chk(input string tag);
    chk({tag, " up"}, {10'h0, pull_up_en}, {10'h0, exp_vec(2'd2)});
    chk({tag, " dn"}, {10'h0, pull_dn_en}, {10'h0, exp_vec(2'd1)});
  endtask

  task automatic busy_chk(input string tag, input logic e);
    bus_addr = 8'hA0;
    #1;
    chk(tag, {63'h0, bus_rdata[0]}, {63'h0, e});
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] other [5];
    other[0] = 8'h90; other[1] = 8'hA0; other[2] = 8'h00;
    other[3] = 8'hA4; other[4] = 8'hFC;
    void'($urandom(32'h5EED1234));
    m_ctrl = 2'd0; m_strobe = '0;
    for (int i = 0; i < NP; i++) m_state[i] = 2'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    out_chk("R1 reset");
    read_chk("R1 ctrl", 8'h94);
    read_chk("R1 bank0", 8'h98);
    read_chk("R1 bank1", 8'h9C);
    busy_chk("R1 status", 1'b0);

    // R2 mode readback, R6 mode write alone leaves outputs
    bus_write(8'h94, 32'hFFFF_FFFD);
    busy_chk("R7 busy at write", 1'b1);
    read_chk("R2 ctrl readback", 8'h94);
    chk("R2 upper zero", {32'h0, bus_rdata}, 64'h1);
    out_chk("R6 mode only");
    repeat (149) @(negedge clk);
    busy_chk("R7 busy last cycle", 1'b1);
    @(negedge clk);
    busy_chk("R7 idle after window", 1'b0);

    // R4/R5 pull-down on pin 5
    bus_write(8'h98, 32'h0000_0020);
    out_chk("R4 load pin5 down");
    chk("R5 dn pin5", {63'h0, pull_dn_en[5]}, 64'h1);
    // R6 strobe stays high: no reload
    bus_write(8'h94, 32'h2);
    bus_write(8'h98, 32'h0000_0020);
    out_chk("R6 held high strobe");
    bus_write(8'h98, 32'h0);
    out_chk("R6 falling strobe");
    bus_write(8'h98, 32'h0000_0020);
    chk("R5 up pin5", {63'h0, pull_up_en[5]}, 64'h1);
    out_chk("R4 reload pin5 up");

    // R5 reserved mode on pin 53, R3 bank1 mask
    bus_write(8'h94, 32'h1);
    bus_write(8'h9C, 32'h0020_0000);
    chk("R5 dn pin53", {63'h0, pull_dn_en[53]}, 64'h1);
    bus_write(8'h9C, 32'h0);
    bus_write(8'h94, 32'h3);
    bus_write(8'h9C, 32'hFFFF_FFFF);
    out_chk("R5 reserved none");
    chk("R5 pin53 none", {62'h0, pull_up_en[53], pull_dn_en[53]}, 64'h0);
    read_chk("R3 bank1 mask", 8'h9C);
    chk("R3 bank1 value", {32'h0, bus_rdata}, 64'h003F_FFFF);

    // R7 retrigger
    repeat (100) @(negedge clk);
    bus_write(8'h98, 32'h0000_0020);
    repeat (149) @(negedge clk);
    busy_chk("R7 retrigger busy", 1'b1);
    @(negedge clk);
    busy_chk("R7 retrigger idle", 1'b0);

    // R8 unmapped write / read
    bus_write(8'hA0, 32'hFFFF_FFFF);
    busy_chk("R8 status write no start", 1'b0);
    bus_write(8'h90, 32'hFFFF_FFFF);
    out_chk("R8 unmapped write");
    read_chk("R8 ctrl kept", 8'h94);
    read_chk("R8 unmapped read", 8'h90);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int kind = $urandom % 5;
      logic [31:0] d = $urandom;
      case (kind)
        0: bus_write(8'h94, d);
        1: bus_write(8'h98, d);
        2: bus_write(8'h9C, d);
        3: bus_write(8'h98, d & m_strobe[31:0]);
        default: bus_write(other[$urandom % 5], d);
      endcase
      out_chk("R4 R6 random");
      chk("R9 exclusive", {10'h0, pull_up_en & pull_dn_en}, 64'h0);
      if (it % 8 == 0) begin
        read_chk("R2 random ctrl", 8'h94);
        read_chk("R3 random bank0", 8'h98);
        read_chk("R3 random bank1", 8'h9C);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule